// File: doc/BRIEF.md
# Priority Interrupt Controller Core

This block gathers up to eight interrupt lines and decides which one the processor should service next. It keeps three per-line state vectors: pending requests, lines in service, and lines masked by software. Line 0 has the highest priority and line 7 the lowest. Each line can be set to respond to a rising edge or to a high level. When an unmasked request outranks everything currently in service, the block raises an interrupt output. The processor then runs a two-pulse acknowledge handshake, and during the second pulse the block returns an 8-bit vector.

Software drives the block through a small write port with four targets:
- the mask register;
- the trigger-mode register;
- a control word that holds the vector base, the special mask flag and the automatic completion flag;
- an end-of-service command, which is either specific (it names a level) or non-specific (it clears the highest in-service line).

With automatic completion enabled, the block clears the in-service bit by itself when the acknowledge handshake ends. Special mask mode lets masked in-service lines stop blocking lower-priority requests.

Top module: `pic_core`

## Requirements
- R1: After reset, `int_out`, `vec_valid` and `vec_out` are 0. All mask bits are 1, all lines use edge triggering, the control word is 0, and no request or in-service bit is set.
- R2: A line with trigger bit 0 records a request only on a low-to-high transition, one cycle after the input rises. While the line stays high, no further request is recorded, even after an end-of-service command.
- R3: A line with trigger bit 1 is requested whenever it is high. If it is still high after its end-of-service command, `int_out` rises again.
- R4: A request whose mask bit is 1 never raises `int_out`.
- R5: `int_out` is 1 exactly when some unmasked request has a lower line number than every counted in-service bit. Every in-service bit counts, except that in special mask mode the masked in-service bits do not.
- R6: At the first falling edge of `inta_n`, the winning request is captured, its in-service bit is set and its request bit is cleared. While `inta_n` is low for the second pulse, `vec_valid` is 1 and `vec_out` = {base[4:0], line[2:0]}.
- R7: If no unmasked request wins at the first falling edge, because the request disappeared, the vector carries line 7 and no in-service bit is set.
- R8: Writing the command target (`wr_sel` = 3) with bit 3 = 0 clears the lowest-numbered counted in-service bit.
- R9: Writing the command target with bit 3 = 1 clears the in-service bit named by bits 2:0 and leaves the others unchanged.
- R10: In special mask mode (control bit 1), a masked in-service bit does not block lower-priority requests, and a non-specific command skips it.
- R11: With automatic completion (control bit 0), a non-specific clear takes place at the rising edge that ends the second acknowledge pulse.
- R12: Write targets are selected by `wr_sel`: 0 = mask, 1 = trigger mode, 2 = control word (bits 7:3 are the vector base), 3 = end-of-service command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq | input | 8 | Interrupt request lines, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target select |
| wr_data | input | 8 | Write data |
| inta_n | input | 1 | Active-low acknowledge pulses |
| int_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector is being driven |
| vec_out | output | 8 | Interrupt vector, 0 when not valid |

## Verification
Some properties are checked on every cycle:
- the vector's upper field always equals the programmed base;
- `int_out` never rises without an unmasked pending request;
- a capture adds exactly one in-service bit and a spurious capture adds none;
- a non-specific command or an automatic completion removes exactly one in-service bit.

Other behaviours need the bench's scenarios:
- nesting order across several lines;
- the difference between edge and level re-triggering after service;
- the spurious line-7 vector when a request is withdrawn early;
- which bit a special-mask clear leaves behind.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    ACK_IDLE   = 2'd0,
    ACK_FIRST  = 2'd1,
    ACK_GAP    = 2'd2,
    ACK_SECOND = 2'd3
  } ack_state_e;

  localparam logic [1:0] SEL_MASK = 2'd0;
  localparam logic [1:0] SEL_TRIG = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [1:0] SEL_CMD  = 2'd3;
endpackage

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  bits,
  output logic          found,
  output logic [IW-1:0] idx
);
  // lowest index wins: scan downward so the last hit is the lowest
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (bits[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pic_req_reg.sv
module pic_req_reg #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq,
  input  logic [N-1:0] trig_level,
  input  logic [N-1:0] clr,
  output logic [N-1:0] irr
);
  logic [N-1:0] irq_q;
  logic [N-1:0] irr_d;
  logic [N-1:0] rise;

  always_comb begin
    rise  = irq & ~irq_q;
    // a request survives only while its line is high, in either mode
    irr_d = irq & (trig_level | irr | rise) & ~clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
      irr   <= '0;
    end else begin
      irq_q <= irq;
      irr   <= irr_d;
    end
  end
endmodule

// File: rtl/pic_ack_fsm.sv
module pic_ack_fsm
  import pic_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic inta_n,
  output logic take,
  output logic second_on,
  output logic done
);
  ack_state_e state_q, state_d;
  logic       inta_q;
  logic       fall, rise;

  always_comb begin
    fall    = inta_q & ~inta_n;
    rise    = ~inta_q & inta_n;
    state_d = state_q;
    take    = 1'b0;
    done    = 1'b0;
    unique case (state_q)
      ACK_IDLE:   if (fall) begin state_d = ACK_FIRST; take = 1'b1; end
      ACK_FIRST:  if (rise) state_d = ACK_GAP;
      ACK_GAP:    if (fall) state_d = ACK_SECOND;
      ACK_SECOND: if (rise) begin state_d = ACK_IDLE; done = 1'b1; end
      default:    state_d = ACK_IDLE;
    endcase
  end

  assign second_on = (state_q == ACK_SECOND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ACK_IDLE;
      inta_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      inta_q  <= inta_n;
    end
  end
endmodule

// File: rtl/pic_core.sv
module pic_core
  import pic_pkg::*;
#(
  parameter int N_IRQ = 8,
  parameter int VEC_W = 8,
  localparam int IDX_W  = $clog2(N_IRQ),
  localparam int BASE_W = VEC_W - IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [VEC_W-1:0] wr_data,
  input  logic             inta_n,
  output logic             int_out,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_out
);
  localparam logic [N_IRQ-1:0] ONE_HOT0 = N_IRQ'(1);
  localparam logic [IDX_W-1:0] LAST_ID  = IDX_W'(N_IRQ - 1);

  logic [N_IRQ-1:0]  imr, imr_d, trig, trig_d, isr, isr_d, irr, irr_clr;
  logic [BASE_W-1:0] base, base_d;
  logic              smm, smm_d, aeoi, aeoi_d;
  logic [IDX_W-1:0]  vec_id, vec_id_d;
  logic              ctrl_en, take, second_on, done;
  logic              eoi_wr, eoi_spec;
  logic [N_IRQ-1:0]  req_pend, isr_block;
  logic              req_found, blk_found;
  logic [IDX_W-1:0]  req_idx, blk_idx;
  logic              grant;

  pic_req_reg #(.N(N_IRQ)) u_req (
    .clk(clk), .rst_n(rst_n), .irq(irq), .trig_level(trig),
    .clr(irr_clr), .irr(irr)
  );

  pic_ack_fsm u_ack (
    .clk(clk), .rst_n(rst_n), .inta_n(inta_n),
    .take(take), .second_on(second_on), .done(done)
  );

  pic_prio_enc #(.N(N_IRQ)) u_req_enc (
    .bits(req_pend), .found(req_found), .idx(req_idx)
  );

  pic_prio_enc #(.N(N_IRQ)) u_isr_enc (
    .bits(isr_block), .found(blk_found), .idx(blk_idx)
  );

  // resolver
  always_comb begin
    req_pend  = irr & ~imr;
    isr_block = smm ? (isr & ~imr) : isr;
    int_out   = req_found & (~blk_found | (req_idx < blk_idx));
    grant     = take & int_out;
    irr_clr   = grant ? (ONE_HOT0 << req_idx) : '0;
  end

  // write decode and next state
  always_comb begin
    eoi_wr   = wr_en & (wr_sel == SEL_CMD);
    eoi_spec = wr_data[IDX_W];
    ctrl_en  = wr_en & (wr_sel == SEL_CTRL);
    imr_d    = (wr_en & (wr_sel == SEL_MASK)) ? wr_data[N_IRQ-1:0] : imr;
    trig_d   = (wr_en & (wr_sel == SEL_TRIG)) ? wr_data[N_IRQ-1:0] : trig;
    base_d   = ctrl_en ? wr_data[VEC_W-1:IDX_W] : base;
    smm_d    = ctrl_en ? wr_data[1] : smm;
    aeoi_d   = ctrl_en ? wr_data[0] : aeoi;
    vec_id_d = take ? (int_out ? req_idx : LAST_ID) : vec_id;

    isr_d = isr;
    if (eoi_wr) begin
      if (eoi_spec)       isr_d[wr_data[IDX_W-1:0]] = 1'b0;
      else if (blk_found) isr_d[blk_idx] = 1'b0;
    end
    if (done && aeoi && blk_found) isr_d[blk_idx] = 1'b0;
    if (grant) isr_d[req_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr    <= '1;
      trig   <= '0;
      base   <= '0;
      smm    <= 1'b0;
      aeoi   <= 1'b0;
      isr    <= '0;
      vec_id <= '0;
    end else begin
      imr    <= imr_d;
      trig   <= trig_d;
      base   <= base_d;
      smm    <= smm_d;
      aeoi   <= aeoi_d;
      isr    <= isr_d;
      vec_id <= vec_id_d;
    end
  end

  assign vec_valid = second_on;
  assign vec_out   = second_on ? {base, vec_id} : '0;
endmodule

// File: rtl/pic_core_chk.sv
module pic_core_chk #(
  parameter int N_IRQ  = 8,
  parameter int VEC_W  = 8,
  parameter int IDX_W  = 3,
  parameter int BASE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              int_out,
  input logic              vec_valid,
  input logic [VEC_W-1:0]  vec_out,
  input logic [BASE_W-1:0] base,
  input logic              aeoi,
  input logic              smm,
  input logic [N_IRQ-1:0]  isr,
  input logic [N_IRQ-1:0]  irr,
  input logic [N_IRQ-1:0]  imr,
  input logic              take,
  input logic              done,
  input logic              eoi_wr,
  input logic              eoi_spec
);
  // R6
  vec_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> vec_out[VEC_W-1:IDX_W] == base);

  // R4
  int_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (irr & ~imr) != '0);

  // R6
  take_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && int_out && !eoi_wr) |=> $countones(isr) == $past($countones(isr)) + 1);

  // R7
  spurious_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !int_out && !eoi_wr) |=> isr == $past(isr));

  // R8
  ns_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && !eoi_spec && !smm && isr != '0 && !take && !done)
      |=> $countones(isr) == $past($countones(isr)) - 1);

  // R11
  auto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && aeoi && !smm && isr != '0 && !eoi_wr && !take)
      |=> $countones(isr) == $past($countones(isr)) - 1);
endmodule

bind pic_core pic_core_chk #(
  .N_IRQ(N_IRQ), .VEC_W(VEC_W), .IDX_W(IDX_W), .BASE_W(BASE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .int_out(int_out), .vec_valid(vec_valid),
  .vec_out(vec_out), .base(base), .aeoi(aeoi), .smm(smm), .isr(isr),
  .irr(irr), .imr(imr), .take(take), .done(done), .eoi_wr(eoi_wr),
  .eoi_spec(eoi_spec)
);

// File: tb/sim_pic_core.sv
module sim_pic_core;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq;
  logic       wr_en;
  logic [1:0] wr_sel;
  logic [7:0] wr_data;
  logic       inta_n;
  logic       int_out, vec_valid;
  logic [7:0] vec_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  pic_core u0 (
    .clk(clk), .rst_n(rst_n), .irq(irq), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .inta_n(inta_n), .int_out(int_out),
    .vec_valid(vec_valid), .vec_out(vec_out)
  );

  function automatic logic [7:0] lowest_line(input logic [7:0] b);
    lowest_line = 8'd7;
    for (int i = 7; i >= 0; i--) if (b[i]) lowest_line = 8'(i);
  endfunction

  function automatic logic [7:0] vec_of(input logic [4:0] bs, input logic [7:0] line);
    vec_of = {bs, line[2:0]};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk);
    irq = v;
    @(negedge clk);
  endtask

  task automatic ack(output logic [7:0] v, output logic vv);
    @(negedge clk) inta_n = 1'b0;
    @(negedge clk) inta_n = 1'b1;
    @(negedge clk) inta_n = 1'b0;
    @(negedge clk);
    v = vec_out; vv = vec_valid;
    inta_n = 1'b1;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below 100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic       vv;
    logic [4:0] bs;
    rst_n = 1'b0; irq = '0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; inta_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 int", {7'd0, int_out}, 8'd0);
    chk("R1 valid", {7'd0, vec_valid}, 8'd0);
    chk("R1 vec", vec_out, 8'd0);
    set_irq(8'h04);
    chk("R1 mask set", {7'd0, int_out}, 8'd0);

    // R12 control word: base 0x14 -> vectors 0xA0+line
    wr(2'd2, 8'hA0);
    wr(2'd0, 8'h00);
    chk("R4 unmask", {7'd0, int_out}, 8'd1);
    ack(v, vv);
    chk("R6 valid", {7'd0, vv}, 8'd1);
    chk("R6 vec line2", v, 8'hA2);
    chk("R2 no retrig", {7'd0, int_out}, 8'd0);
    wr(2'd3, 8'h00);
    chk("R2 held high after eoi", {7'd0, int_out}, 8'd0);
    set_irq(8'h00);

    // R5 nesting
    set_irq(8'h20);
    ack(v, vv);
    chk("R5 vec5", v, 8'hA5);
    set_irq(8'h60);
    chk("R5 lower blocked", {7'd0, int_out}, 8'd0);
    set_irq(8'h62);
    chk("R5 higher passes", {7'd0, int_out}, 8'd1);
    ack(v, vv);
    chk("R5 vec1", v, 8'hA1);
    wr(2'd3, 8'h00);
    chk("R8 clears 1 only", {7'd0, int_out}, 8'd0);
    wr(2'd3, 8'h00);
    chk("R8 clears 5", {7'd0, int_out}, 8'd1);
    ack(v, vv);
    chk("R8 vec6", v, 8'hA6);
    set_irq(8'h68);
    ack(v, vv);
    chk("R9 vec3", v, 8'hA3);
    wr(2'd3, 8'h0E);
    set_irq(8'h78);
    chk("R9 line3 kept", {7'd0, int_out}, 8'd0);
    wr(2'd3, 8'h00);
    chk("R9 line4 free", {7'd0, int_out}, 8'd1);
    ack(v, vv);
    chk("R9 vec4", v, 8'hA4);
    wr(2'd3, 8'h00);
    set_irq(8'hF8);
    chk("R9 line6 cleared", {7'd0, int_out}, 8'd1);
    ack(v, vv);
    chk("R9 vec7", v, 8'hA7);
    wr(2'd3, 8'h00);
    set_irq(8'h00);

    // R3 level mode on line 0
    wr(2'd1, 8'h01);
    set_irq(8'h01);
    ack(v, vv);
    chk("R3 vec0", v, 8'hA0);
    chk("R3 in service", {7'd0, int_out}, 8'd0);
    wr(2'd3, 8'h00);
    chk("R3 re-request", {7'd0, int_out}, 8'd1);

    // R7 spurious: drop before first pulse
    set_irq(8'h00);
    ack(v, vv);
    chk("R7 default vec", v, 8'hA7);
    set_irq(8'h80);
    chk("R7 isr7 untouched", {7'd0, int_out}, 8'd1);
    ack(v, vv);
    wr(2'd3, 8'h00);
    wr(2'd3, 8'h00);
    set_irq(8'h00);

    // R11 automatic completion
    wr(2'd2, 8'hA1);
    set_irq(8'h08);
    ack(v, vv);
    chk("R11 vec3", v, 8'hA3);
    set_irq(8'h28);
    chk("R11 auto cleared", {7'd0, int_out}, 8'd1);
    ack(v, vv);
    chk("R11 vec5", v, 8'hA5);
    set_irq(8'h00);

    // R10 special mask mode
    wr(2'd2, 8'hA2);
    set_irq(8'h04);
    ack(v, vv);
    chk("R10 vec2", v, 8'hA2);
    wr(2'd0, 8'h04);
    set_irq(8'h44);
    chk("R10 masked isr no block", {7'd0, int_out}, 8'd1);
    ack(v, vv);
    chk("R10 vec6", v, 8'hA6);
    wr(2'd3, 8'h00);
    wr(2'd2, 8'hA0);
    wr(2'd0, 8'h00);
    set_irq(8'hC4);
    chk("R10 line2 survived", {7'd0, int_out}, 8'd0);
    wr(2'd3, 8'h00);
    chk("R10 line2 cleared", {7'd0, int_out}, 8'd1);
    ack(v, vv);
    wr(2'd3, 8'h00);
    set_irq(8'h00);

    // R5 R6 random in level mode
    void'($urandom(32'd1234));
    wr(2'd1, 8'hFF);
    for (int n = 0; n < 24; n++) begin
      logic [7:0] m, r;
      bs = 5'($urandom);
      m  = 8'($urandom);
      r  = 8'($urandom);
      wr(2'd2, {bs, 3'b000});
      wr(2'd0, m);
      set_irq(r);
      chk("R5 random int", {7'd0, int_out}, {7'd0, ((r & ~m) != 0)});
      ack(v, vv);
      chk("R6 random vec", v, vec_of(bs, lowest_line(r & ~m)));
      set_irq(8'h00);
      wr(2'd3, 8'h00);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule